// File: doc/BRIEF.md
# GMII Receive Error-Policy Filter

This block sits on the receive side of a gigabit Ethernet MAC and takes the byte-wide receive bus from the PHY: one byte per 125 MHz clock, a data-valid qualifier and a receive-error flag. It also takes carrier sense, collision and a link-status input. It discards everything up to and including the start-of-frame delimiter (0xD5). The frame bytes that follow go out as a byte stream with valid, last and error qualifiers.

Frames are held in an internal ring buffer until they end. Frames that are kept are then released as one unbroken burst, and frames that are discarded leave no trace at the output. A configuration input decides what happens to frames during which the PHY flagged a receive error. Such a frame is either forwarded with the error qualifier on its final beat or dropped entirely. While the link is down the receive bus is ignored. A one-cycle alert pulse reports every change of link or carrier state.

Top module: `gmii_rx_filter`

## Requirements
- R1: After reset, `out_valid` and `status_chg` are low, and no beat appears until a frame has been received.
- R2: For a frame of preamble, 0xD5 and N payload bytes, the output carries exactly the N payload bytes in arrival order. `out_last` is high only on the Nth beat.
- R3: Every byte before the first 0xD5 of a frame is discarded, whatever its value and however many there are. A 0xD5 that arrives after the delimiter is passed on as data.
- R4: A burst of `rx_dv` that ends before any 0xD5 is seen produces no output beat.
- R5: With `drop_err_frames` low, a frame during which `rx_er` was high with `rx_dv` (in the preamble or the payload) is forwarded complete. `out_err` is 1 on its last beat and 0 on all its other beats.
- R6: With `drop_err_frames` high, such a frame produces no output beat. Clean frames still pass.
- R7: While `link_up` is low, received bytes produce no output. A frame during which `link_up` falls is discarded.
- R8: Each change of `link_up` or `rx_crs` sampled at a clock edge makes `status_chg` high for exactly the following cycle.
- R9: `rx_col` has no effect on the output stream.
- R10: Frames are output in arrival order, including frames separated by a single idle cycle. Once the first beat of a frame appears, `out_valid` stays high until that frame's last beat.
- R11: A delimiter followed at once by the end of `rx_dv` (zero payload bytes) produces no output beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_d | input | 8 | Receive byte from the PHY |
| rx_dv | input | 1 | Receive data valid |
| rx_er | input | 1 | Receive error from the PHY |
| rx_crs | input | 1 | Carrier sense |
| rx_col | input | 1 | Collision indication (ignored, full-duplex) |
| link_up | input | 1 | Link present |
| drop_err_frames | input | 1 | 1: drop frames that saw an error; 0: forward them with the flag set |
| out_valid | output | 1 | Output beat valid |
| out_data | output | 8 | Output frame byte |
| out_last | output | 1 | Final beat of a frame |
| out_err | output | 1 | Frame saw a receive error (last beat only) |
| status_chg | output | 1 | One-cycle link/carrier change alert |

## Verification
A kept frame is committed on the clock edge that samples `rx_dv` low. Its first beat is visible in the cycle after the next edge, and its N beats are over by N+2 cycles after `rx_dv` falls. The bench therefore drives inputs on falling edges and records every beat on falling edges. It compares the recorded beats only after a settle window of payload length plus eight cycles, so an empty record also proves that a frame was dropped. An alert is sampled one falling edge after the input change, where it must be high, and again one edge later, where it must be low.

// File: rtl/gmii_rx_pkg.sv
package gmii_rx_pkg;

    localparam logic [7:0] SFD_BYTE = 8'hD5;

    typedef struct packed {
        logic [7:0] data;
        logic       last;
        logic       err;
    } beat_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HUNT,
        ST_DATA
    } rx_state_e;

endpackage

// File: rtl/gmii_rx_framer.sv
module gmii_rx_framer
    import gmii_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] rx_d,
    input  logic       rx_dv,
    input  logic       rx_er,
    input  logic       link_up,
    input  logic       drop_err,
    input  logic       buf_full,
    output logic       wr_en,
    output beat_t      wr_beat,
    output logic       commit,
    output logic       abort
);

    typedef struct packed {
        rx_state_e  st;
        logic [7:0] pend;
        logic       have;
        logic       err;
        logic       ovf;
    } fr_t;

    fr_t fr_d, fr_q;

    always_comb begin
        fr_d    = fr_q;
        wr_en   = 1'b0;
        wr_beat = '0;
        commit  = 1'b0;
        abort   = 1'b0;
        if (!link_up) begin
            abort = (fr_q.st == ST_DATA);
            fr_d  = '{st: ST_IDLE, pend: 8'h00, have: 1'b0, err: 1'b0, ovf: 1'b0};
        end else begin
            case (fr_q.st)
                ST_IDLE: begin
                    if (rx_dv) begin
                        fr_d.err = rx_er;
                        fr_d.st  = (rx_d == SFD_BYTE) ? ST_DATA : ST_HUNT;
                    end
                end
                ST_HUNT: begin
                    if (!rx_dv) begin
                        fr_d.st  = ST_IDLE;
                        fr_d.err = 1'b0;
                    end else begin
                        fr_d.err = fr_q.err | rx_er;
                        if (rx_d == SFD_BYTE) begin
                            fr_d.st = ST_DATA;
                        end
                    end
                end
                ST_DATA: begin
                    if (rx_dv) begin
                        fr_d.err = fr_q.err | rx_er;
                        if (fr_q.have) begin
                            if (buf_full) begin
                                fr_d.ovf = 1'b1;
                            end else begin
                                wr_en   = 1'b1;
                                wr_beat = '{data: fr_q.pend, last: 1'b0, err: 1'b0};
                            end
                        end
                        fr_d.pend = rx_d;
                        fr_d.have = 1'b1;
                    end else begin
                        if (fr_q.have) begin
                            if (!buf_full) begin
                                wr_en   = 1'b1;
                                wr_beat = '{data: fr_q.pend, last: 1'b1, err: fr_q.err};
                            end
                            if (fr_q.ovf || buf_full || (drop_err && fr_q.err)) begin
                                abort = 1'b1;
                            end else begin
                                commit = 1'b1;
                            end
                        end
                        fr_d = '{st: ST_IDLE, pend: 8'h00, have: 1'b0, err: 1'b0, ovf: 1'b0};
                    end
                end
                default: fr_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q <= '{st: ST_IDLE, pend: 8'h00, have: 1'b0, err: 1'b0, ovf: 1'b0};
        end else begin
            fr_q <= fr_d;
        end
    end

    // R7
    link_down_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |-> (!wr_en && !commit));

    // R6
    err_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !(drop_err && fr_q.err));

    // R4
    hunt_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q.st != ST_DATA) |-> (!wr_en && !commit));

endmodule

// File: rtl/gmii_rx_ring.sv
module gmii_rx_ring
    import gmii_rx_pkg::*;
#(
    parameter int MAX_FRAME = 1522
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  beat_t wr_beat,
    input  logic  commit,
    input  logic  abort,
    output logic  full,
    output beat_t out_beat,
    output logic  out_valid
);

    localparam int AW    = $clog2(MAX_FRAME);
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [AW:0] wr;
        logic [AW:0] cm;
        logic [AW:0] rd;
        logic        valid;
        beat_t       beat;
    } ring_t;

    ring_t r_d, r_q;
    beat_t mem [DEPTH];
    logic [AW:0] used;

    assign used      = r_q.wr - r_q.rd;
    assign full      = used[AW];
    assign out_beat  = r_q.beat;
    assign out_valid = r_q.valid;

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        if (wr_en && !full) begin
            r_d.wr = r_q.wr + 1'b1;
        end
        if (abort) begin
            r_d.wr = r_q.cm;
        end else if (commit) begin
            r_d.cm = r_d.wr;
        end
        if (r_q.rd != r_q.cm) begin
            r_d.valid = 1'b1;
            r_d.beat  = mem[r_q.rd[AW-1:0]];
            r_d.rd    = r_q.rd + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !full) begin
            mem[r_q.wr[AW-1:0]] <= wr_beat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // R10
    burst_unbroken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.valid && !r_q.beat.last) |=> r_q.valid);

    // R5
    err_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.valid && r_q.beat.err) |-> r_q.beat.last);

endmodule

// File: rtl/gmii_rx_alert.sv
module gmii_rx_alert (
    input  logic clk,
    input  logic rst_n,
    input  logic link_up,
    input  logic crs,
    output logic status_chg
);

    typedef struct packed {
        logic armed;
        logic link;
        logic crs;
        logic pulse;
    } al_t;

    al_t al_d, al_q;

    always_comb begin
        al_d       = al_q;
        al_d.armed = 1'b1;
        al_d.link  = link_up;
        al_d.crs   = crs;
        al_d.pulse = al_q.armed && ((link_up != al_q.link) || (crs != al_q.crs));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            al_q <= '0;
        end else begin
            al_q <= al_d;
        end
    end

    assign status_chg = al_q.pulse;

    // R8
    quiet_inputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(link_up) && $stable(crs)) |=> !status_chg);

endmodule

// File: rtl/gmii_rx_filter.sv
module gmii_rx_filter
    import gmii_rx_pkg::*;
#(
    parameter int MAX_FRAME = 1522
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] rx_d,
    input  logic       rx_dv,
    input  logic       rx_er,
    input  logic       rx_crs,
    input  logic       rx_col,
    input  logic       link_up,
    input  logic       drop_err_frames,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_last,
    output logic       out_err,
    output logic       status_chg
);

    logic  wr_en, commit, abort, full;
    beat_t wr_beat, out_beat;
    logic  col_unused;

    assign col_unused = rx_col;

    gmii_rx_framer u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_d     (rx_d),
        .rx_dv    (rx_dv),
        .rx_er    (rx_er),
        .link_up  (link_up),
        .drop_err (drop_err_frames),
        .buf_full (full),
        .wr_en    (wr_en),
        .wr_beat  (wr_beat),
        .commit   (commit),
        .abort    (abort)
    );

    gmii_rx_ring #(.MAX_FRAME(MAX_FRAME)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_beat   (wr_beat),
        .commit    (commit),
        .abort     (abort),
        .full      (full),
        .out_beat  (out_beat),
        .out_valid (out_valid)
    );

    gmii_rx_alert u_alert (
        .clk        (clk),
        .rst_n      (rst_n),
        .link_up    (link_up),
        .crs        (rx_crs),
        .status_chg (status_chg)
    );

    assign out_data = out_beat.data;
    assign out_last = out_beat.last;
    assign out_err  = out_beat.err;

endmodule

// File: tb/tb_gmii_rx_filter.sv
module tb_gmii_rx_filter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rx_d = 8'h00;
    logic       rx_dv = 1'b0, rx_er = 1'b0, rx_crs = 1'b0, rx_col = 1'b0;
    logic       link_up = 1'b0, drop_err_frames = 1'b0;
    logic       out_valid, out_last, out_err, status_chg;
    logic [7:0] out_data;

    int checks = 0;
    int errors = 0;
    int gap_err = 0;
    bit done = 1'b0;
    bit open_q = 1'b0;
    logic [9:0] got[$];

    always #10 clk = ~clk;

    gmii_rx_filter dut (
        .clk(clk), .rst_n(rst_n), .rx_d(rx_d), .rx_dv(rx_dv), .rx_er(rx_er),
        .rx_crs(rx_crs), .rx_col(rx_col), .link_up(link_up),
        .drop_err_frames(drop_err_frames), .out_valid(out_valid),
        .out_data(out_data), .out_last(out_last), .out_err(out_err),
        .status_chg(status_chg)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) got.push_back({out_data, out_last, out_err});
            if (open_q && !out_valid) gap_err++;
            open_q = out_valid && !out_last;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [7:0] b[$], input int er_at, input int down_at);
        foreach (b[i]) begin
            @(negedge clk);
            rx_dv = 1'b1;
            rx_d  = b[i];
            rx_er = (i == er_at);
            if (i == down_at) link_up = 1'b0;
        end
        @(negedge clk);
        rx_dv = 1'b0;
        rx_er = 1'b0;
        rx_d  = 8'h00;
    endtask

    task automatic expect_beats(input logic [7:0] pay[$], input bit err_last, input string req);
        repeat (pay.size() + 8) @(negedge clk);
        chk(got.size() == pay.size(), req, "beat count", got.size(), pay.size());
        if (got.size() == pay.size()) begin
            foreach (pay[i]) begin
                bit lst = (i == pay.size() - 1);
                logic [9:0] exp = {pay[i], lst, err_last && lst};
                chk(got[i] == exp, req, "beat", got[i], exp);
            end
        end
        got.delete();
    endtask

    function automatic void std_frame(ref logic [7:0] f[$], input logic [7:0] pay[$]);
        f.delete();
        repeat (7) f.push_back(8'h55);
        f.push_back(8'hD5);
        foreach (pay[i]) f.push_back(pay[i]);
    endfunction

    task automatic alert_case(input bit nl, input bit nc, input string req);
        @(negedge clk);
        link_up = nl;
        rx_crs  = nc;
        @(negedge clk);
        chk(status_chg == 1'b1, req, "alert high", status_chg, 1);
        @(negedge clk);
        chk(status_chg == 1'b0, req, "alert one cycle", status_chg, 0);
    endtask

    task automatic t_reset();
        // R1
        chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        chk(status_chg == 1'b0, "R1", "status_chg in reset", status_chg, 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        chk(got.size() == 0, "R1", "no beats", got.size(), 0);
    endtask

    task automatic t_basic();
        logic [7:0] f[$];
        logic [7:0] p[$] = '{8'h01, 8'h02, 8'h03, 8'hA5, 8'h5A, 8'hFF};
        std_frame(f, p);
        drive(f, -1, -1);
        expect_beats(p, 1'b0, "R2");
    endtask

    task automatic t_odd_preamble();
        logic [7:0] f[$] = '{8'h12, 8'hAA, 8'h55, 8'hD5, 8'h10, 8'hD5, 8'h20, 8'h30};
        logic [7:0] p[$] = '{8'h10, 8'hD5, 8'h20, 8'h30};
        drive(f, -1, -1);
        expect_beats(p, 1'b0, "R3");
    endtask

    task automatic t_fragment();
        logic [7:0] f[$] = '{8'h55, 8'h55, 8'h55, 8'h55, 8'h55};
        logic [7:0] p[$];
        drive(f, -1, -1);
        expect_beats(p, 1'b0, "R4");
    endtask

    task automatic t_err_forward();
        logic [7:0] f[$];
        logic [7:0] p[$] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
        std_frame(f, p);
        drop_err_frames = 1'b0;
        drive(f, 9, -1);
        expect_beats(p, 1'b1, "R5");
        drive(f, 2, -1);
        expect_beats(p, 1'b1, "R5");
    endtask

    task automatic t_err_drop();
        logic [7:0] f[$];
        logic [7:0] p[$] = '{8'h66, 8'h77, 8'h88};
        logic [7:0] none[$];
        std_frame(f, p);
        drop_err_frames = 1'b1;
        drive(f, 9, -1);
        expect_beats(none, 1'b0, "R6");
        drive(f, 3, -1);
        expect_beats(none, 1'b0, "R6");
        drive(f, -1, -1);
        expect_beats(p, 1'b0, "R6");
        drop_err_frames = 1'b0;
    endtask

    task automatic t_link_down();
        logic [7:0] f[$];
        logic [7:0] p[$] = '{8'hC1, 8'hC2, 8'hC3, 8'hC4};
        logic [7:0] none[$];
        std_frame(f, p);
        alert_case(1'b0, 1'b0, "R8");
        drive(f, -1, -1);
        expect_beats(none, 1'b0, "R7");
        alert_case(1'b1, 1'b0, "R8");
        drive(f, -1, 9);
        expect_beats(none, 1'b0, "R7");
        @(negedge clk); link_up = 1'b1;
        repeat (3) @(negedge clk);
        drive(f, -1, -1);
        expect_beats(p, 1'b0, "R7");
    endtask

    task automatic t_collision();
        logic [7:0] f[$];
        logic [7:0] p[$] = '{8'h0A, 8'h0B, 8'h0C};
        std_frame(f, p);
        rx_col = 1'b1;
        drive(f, -1, -1);
        rx_col = 1'b0;
        expect_beats(p, 1'b0, "R9");
    endtask

    task automatic t_back_to_back();
        logic [7:0] f1[$], f2[$];
        logic [7:0] p1[$] = '{8'hE1, 8'hE2, 8'hE3, 8'hE4, 8'hE5, 8'hE6, 8'hE7};
        logic [7:0] p2[$] = '{8'hF1, 8'hF2, 8'hF3};
        logic [7:0] all[$];
        std_frame(f1, p1);
        std_frame(f2, p2);
        gap_err = 0;
        drive(f1, -1, -1);
        drive(f2, -1, -1);
        repeat (p1.size() + p2.size() + 8) @(negedge clk);
        chk(got.size() == p1.size() + p2.size(), "R10", "total beats", got.size(), 10);
        if (got.size() == 10) begin
            foreach (p1[i]) chk(got[i][9:2] == p1[i], "R10", "frame1 byte", got[i][9:2], p1[i]);
            chk(got[6][1] == 1'b1, "R10", "frame1 last", got[6][1], 1);
            foreach (p2[i]) chk(got[7+i][9:2] == p2[i], "R10", "frame2 byte", got[7+i][9:2], p2[i]);
            chk(got[9][1] == 1'b1, "R10", "frame2 last", got[9][1], 1);
        end
        chk(gap_err == 0, "R10", "gaps inside frames", gap_err, 0);
        got.delete();
        all.delete();
    endtask

    task automatic t_empty();
        logic [7:0] f[$] = '{8'h55, 8'h55, 8'hD5};
        logic [7:0] none[$];
        drive(f, -1, -1);
        expect_beats(none, 1'b0, "R11");
    endtask

    task automatic t_carrier();
        alert_case(1'b1, 1'b1, "R8");
        alert_case(1'b1, 1'b0, "R8");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        alert_case(1'b1, 1'b0, "R8");
        t_basic();
        t_odd_preamble();
        t_fragment();
        t_err_forward();
        t_err_drop();
        t_link_down();
        t_collision();
        t_back_to_back();
        t_empty();
        t_carrier();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule